// File: doc/BRIEF.md
# Three-Sample Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with a transmitter and a receiver that share one oversampling tick. The tick is derived from the system clock through a programmable divisor, so one bit lasts sixteen ticks. A host writes bytes with a one-cycle strobe while a ready flag is high. It collects received bytes through a valid flag and a one-cycle read strobe.

The receiver synchronises the serial line and looks for a low level on a tick. It then takes three samples of every bit, one tick apart, around the bit centre. This applies to the start and stop bits as well as the data bits. The bit value is the majority of the three samples. Any disagreement among the three marks the character with a noise error, but the character is still delivered. A start bit that reads high at its centre is treated as a glitch and dropped. A low stop bit marks a framing error, and the receiver then waits for the line to go high before it hunts again. Parity can be none, even or odd and is shared by both directions.

Top module: `uart3s`

## Requirements
- R1: The oversampling tick fires once every baudDiv+1 clock cycles. Every transmitted bit lasts exactly 16 ticks, so the start bit stays low for 16*(baudDiv+1) cycles.
- R2: A transmitted frame is one low start bit, then 8 data bits with the least significant bit first, then the parity bit when enabled, then one high stop bit. txd is high whenever the transmitter is idle.
- R3: txReady is high only while the transmitter is idle. A txWrite while txReady is high is accepted and drops txReady on the next cycle. A txWrite while txReady is low is ignored: it changes neither the frame in progress nor what follows it.
- R4: parityMode encodes 0 = no parity, 1 = even, 2 = odd, 3 = no parity. Even parity makes the count of ones over data and parity even. Odd parity makes that count odd.
- R5: The receiver samples each bit three times, one tick apart, at ticks 7, 8 and 9 of its 16 ticks, counted from the tick that saw the start level low. It keeps the majority value.
- R6: If the three samples of any bit disagree (start, data, parity or stop), errNoise is set with that character. The majority byte is still delivered.
- R7: A start bit whose majority reads high is discarded without any delivery, and the receiver resumes hunting.
- R8: A stop bit whose majority is low sets errFrame with that character. No new character is started until the line has been seen high again.
- R9: With parity enabled, a received parity bit that breaks the selected parity sets errParity with that character.
- R10: On delivery, rxData, errFrame, errParity and errNoise are updated together and rxValid is set. rxValid stays set until rxRead. If a delivery and rxRead fall in the same cycle, the delivery wins and rxValid stays set. rxData changes only on a delivery.
- R11: After reset, txd = 1, txReady = 1, rxValid = 0 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudDiv | input | 16 | Tick divisor; tick period is baudDiv+1 cycles |
| parityMode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| txData | input | 8 | Byte to transmit |
| txWrite | input | 1 | One-cycle strobe to start a transmission |
| txReady | output | 1 | Transmitter idle and able to accept a byte |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | A received byte is waiting |
| rxRead | input | 1 | One-cycle strobe that consumes the waiting byte |
| errFrame | output | 1 | Stop bit of the last character was low |
| errParity | output | 1 | Parity of the last character was wrong |
| errNoise | output | 1 | Some bit of the last character had disagreeing samples |

## Verification
The host read strobe and the end of a received character can land on the same clock edge, and the delivery has to take precedence. The bench provokes this by holding rxRead high through a whole incoming frame. It judges the result by requiring rxValid to be high for exactly one cycle, with the new byte present in that cycle. Transmission and reception also run at the same time in a loopback run, where txd drives rxd and both directions are checked.

// File: rtl/uart3s_pkg.sv
package uart3s_pkg;

  // Role of the bit currently handled by either direction.
  typedef enum logic [1:0] {
    K_START = 2'd0,
    K_DATA  = 2'd1,
    K_PAR   = 2'd2,
    K_STOP  = 2'd3
  } bitKind_t;

  // Strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic     txLoad;
    logic     txOut;
    bitKind_t txKind;
    logic     rxClr;
    logic     rxTake;
    logic     rxEval;
    bitKind_t rxKind;
  } strobe_t;

  function automatic logic parityEnabled(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

endpackage

// File: rtl/uart3s_ctrl.sv
module uart3s_ctrl
  import uart3s_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    rxS,
  input  logic    vote,
  input  logic    parOn,
  input  logic    txWrite,
  output logic    txReady,
  output strobe_t stb
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] SMP_LO  = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] SMP_HI  = CW'(OVS / 2);
  localparam logic [CW-1:0] EVAL_AT = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(OVS - 1);
  localparam logic [IW-1:0] DATA_END = IW'(DATA_W);

  typedef enum logic [1:0] {R_IDLE, R_BIT, R_WAITHI} rxState_t;
  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_RUN} txState_t;

  rxState_t      rxState;
  logic [CW-1:0] rxCnt;
  logic [IW-1:0] rxIdx;
  txState_t      txState;
  logic [CW-1:0] txCnt;
  logic [IW-1:0] txIdx;

  logic [IW-1:0] lastIdx;
  logic [IW-1:0] txNext;
  bitKind_t      rxKindNow;
  logic          rxStartNow;
  logic          rxEvalNow;
  logic          txBitEnd;

  // Bit index 0 is the start bit, 1..DATA_W data, then parity (optional), then stop.
  function automatic bitKind_t kindOf(input logic [IW-1:0] idx, input logic [IW-1:0] last);
    if (idx == '0)       return K_START;
    if (idx <= DATA_END) return K_DATA;
    if (idx == last)     return K_STOP;
    return K_PAR;
  endfunction

  assign lastIdx    = parOn ? IW'(DATA_W + 2) : IW'(DATA_W + 1);
  assign rxKindNow  = kindOf(rxIdx, lastIdx);
  assign rxStartNow = (rxState == R_IDLE) && tick && !rxS;
  assign rxEvalNow  = (rxState == R_BIT) && tick && (rxCnt == EVAL_AT);
  assign txNext     = txIdx + 1'b1;
  assign txBitEnd   = (txState == T_RUN) && tick && (txCnt == CNT_TOP);
  assign txReady    = (txState == T_IDLE);

  always_comb begin
    stb        = '0;
    stb.rxClr  = rxStartNow;
    stb.rxTake = (rxState == R_BIT) && tick && (rxCnt >= SMP_LO) && (rxCnt <= SMP_HI);
    stb.rxEval = rxEvalNow;
    stb.rxKind = rxKindNow;
    stb.txLoad = (txState == T_IDLE) && txWrite;
    stb.txOut  = ((txState == T_WAIT) && tick) || (txBitEnd && (txNext <= lastIdx));
    stb.txKind = (txState == T_WAIT) ? K_START : kindOf(txNext, lastIdx);
  end

  // Receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= R_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        R_IDLE: begin
          if (rxStartNow) begin
            rxState <= R_BIT;
            rxCnt   <= '0;
            rxIdx   <= '0;
          end
        end
        R_BIT: begin
          if (tick) begin
            rxCnt <= rxCnt + 1'b1;
            if (rxCnt == CNT_TOP) rxIdx <= rxIdx + 1'b1;
            if (rxEvalNow && (rxKindNow == K_START) && vote) begin
              rxState <= R_IDLE;
            end else if (rxEvalNow && (rxKindNow == K_STOP)) begin
              rxState <= vote ? R_IDLE : R_WAITHI;
            end
          end
        end
        R_WAITHI: begin
          if (rxS) rxState <= R_IDLE;
        end
        default: rxState <= R_IDLE;
      endcase
    end
  end

  // Transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= T_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
    end else begin
      case (txState)
        T_IDLE: begin
          if (txWrite) txState <= T_WAIT;
        end
        T_WAIT: begin
          if (tick) begin
            txState <= T_RUN;
            txCnt   <= '0;
            txIdx   <= '0;
          end
        end
        T_RUN: begin
          if (tick) begin
            txCnt <= txCnt + 1'b1;
            if (txCnt == CNT_TOP) begin
              txIdx <= txNext;
              if (txNext > lastIdx) txState <= T_IDLE;
            end
          end
        end
        default: txState <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart3s_dp.sv
module uart3s_dp
  import uart3s_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [1:0]        parityMode,
  input  logic              rxd,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  strobe_t           stb,
  output logic              tick,
  output logic              rxS,
  output logic              vote,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              errFrame,
  output logic              errParity,
  output logic              errNoise
);

  logic [DIV_W-1:0]  baudCnt;
  logic [1:0]        syncQ;
  logic [2:0]        smp;
  logic              agree;
  logic              oddMode;
  logic [DATA_W-1:0] rxSh;
  logic              parAcc;
  logic              parErrR;
  logic              noiseAcc;
  logic [DATA_W-1:0] txSh;
  logic              txParBit;

  assign oddMode = (parityMode == 2'b10);

  // Oversampling tick generator
  assign tick = (baudCnt >= baudDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baudCnt <= '0;
    else       baudCnt <= tick ? '0 : baudCnt + 1'b1;
  end

  // Two-stage line synchroniser, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end
  assign rxS = syncQ[1];

  // Three-sample window and its vote
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           smp <= 3'b111;
    else if (stb.rxTake) smp <= {smp[1:0], rxS};
  end

  assign vote  = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  assign agree = (smp == 3'b000) || (smp == 3'b111);

  // Receive accumulation and delivery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      parAcc    <= 1'b0;
      parErrR   <= 1'b0;
      noiseAcc  <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      errFrame  <= 1'b0;
      errParity <= 1'b0;
      errNoise  <= 1'b0;
    end else begin
      if (stb.rxClr) begin
        parAcc   <= 1'b0;
        parErrR  <= 1'b0;
        noiseAcc <= 1'b0;
      end
      if (stb.rxEval) begin
        noiseAcc <= noiseAcc | !agree;
        case (stb.rxKind)
          K_DATA: begin
            rxSh   <= {vote, rxSh[DATA_W-1:1]};
            parAcc <= parAcc ^ vote;
          end
          K_PAR: parErrR <= parAcc ^ vote ^ oddMode;
          default: ;
        endcase
      end
      if (stb.rxEval && (stb.rxKind == K_STOP)) begin
        rxData    <= rxSh;
        errFrame  <= !vote;
        errParity <= parErrR;
        errNoise  <= noiseAcc | !agree;
        rxValid   <= 1'b1;
      end else if (rxRead) begin
        rxValid <= 1'b0;
      end
    end
  end

  // Transmit shifting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      txParBit <= 1'b0;
      txd      <= 1'b1;
    end else begin
      if (stb.txLoad) begin
        txSh     <= txData;
        txParBit <= (^txData) ^ oddMode;
      end
      if (stb.txOut) begin
        case (stb.txKind)
          K_START: txd <= 1'b0;
          K_DATA: begin
            txd  <= txSh[0];
            txSh <= txSh >> 1;
          end
          K_PAR:   txd <= txParBit;
          default: txd <= 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart3s.sv
module uart3s
  import uart3s_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [1:0]        parityMode,
  input  logic              rxd,
  output logic              txd,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxRead,
  output logic              errFrame,
  output logic              errParity,
  output logic              errNoise
);

  strobe_t stb;
  logic    tick;
  logic    rxS;
  logic    vote;
  logic    parOn;

  assign parOn = parityEnabled(parityMode);

  uart3s_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .rxS     (rxS),
    .vote    (vote),
    .parOn   (parOn),
    .txWrite (txWrite),
    .txReady (txReady),
    .stb     (stb)
  );

  uart3s_dp #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .baudDiv    (baudDiv),
    .parityMode (parityMode),
    .rxd        (rxd),
    .txData     (txData),
    .rxRead     (rxRead),
    .stb        (stb),
    .tick       (tick),
    .rxS        (rxS),
    .vote       (vote),
    .txd        (txd),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .errFrame   (errFrame),
    .errParity  (errParity),
    .errNoise   (errNoise)
  );

endmodule

// File: rtl/uart3s_chk.sv
module uart3s_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txd,
  input logic              txReady,
  input logic              txWrite,
  input logic              rxValid,
  input logic              rxRead,
  input logic [DATA_W-1:0] rxData,
  input logic              errFrame,
  input logic              errNoise
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txd); // R2

  AST_STOP_BEFORE_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> (txd && $past(txd))); // R2

  AST_WRITE_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txWrite) |=> !txReady); // R3

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxRead) |=> rxValid); // R10

  AST_DATA_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxValid); // R10

  AST_NOISE_WITH_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errNoise) |-> rxValid); // R6

  AST_FRAME_WITH_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFrame) |-> rxValid); // R8

endmodule

bind uart3s uart3s_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .txd      (txd),
  .txReady  (txReady),
  .txWrite  (txWrite),
  .rxValid  (rxValid),
  .rxRead   (rxRead),
  .rxData   (rxData),
  .errFrame (errFrame),
  .errNoise (errNoise)
);

// File: tb/sim_uart3s.sv
`timescale 1ns/1ps
module sim_uart3s;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baudDiv = 16'd3;
  logic [1:0]  parityMode = 2'd0;
  logic        rxdDrv = 1'b1;
  logic        loop = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txWrite = 1'b0;
  logic        rxRead = 1'b0;
  wire         rxd;
  logic        txd, txReady, rxValid, errFrame, errParity, errNoise;
  logic [7:0]  rxData;

  int checks = 0;
  int fails = 0;
  int P = 4;

  assign rxd = loop ? txd : rxdDrv;

  always #2.5 clk = ~clk;

  uart3s u0 (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .parityMode(parityMode),
    .rxd(rxd), .txd(txd), .txData(txData), .txWrite(txWrite), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxRead(rxRead),
    .errFrame(errFrame), .errParity(errParity), .errNoise(errNoise)
  );

  // Reference record of observed deliveries (port level only)
  int         seenCnt = 0;
  int         hiCnt = 0;
  logic       prevV = 1'b0;
  logic [7:0] seenData = 8'h00;
  logic       seenFr = 1'b0, seenPar = 1'b0, seenNz = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) hiCnt++;
      if (rxValid && !prevV) begin
        seenCnt++;
        seenData = rxData;
        seenFr = errFrame;
        seenPar = errParity;
        seenNz = errNoise;
      end
      prevV = rxValid;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic v, input bit noisy);
    for (int c = 0; c < 16 * P; c++) begin
      @(negedge clk);
      rxdDrv = (noisy && c >= 8 * P && c < 9 * P) ? ~v : v;
    end
  endtask

  // idx numbering: 0 start, 1..8 data, then parity (if used), then stop
  task automatic sendFrame(input logic [7:0] d, input bit usePar, input logic parBit,
                           input logic stopV, input int noiseIdx);
    int idx = 0;
    sendBit(1'b0, noiseIdx == idx); idx++;
    for (int i = 0; i < 8; i++) begin
      sendBit(d[i], noiseIdx == idx); idx++;
    end
    if (usePar) begin
      sendBit(parBit, noiseIdx == idx); idx++;
    end
    sendBit(stopV, noiseIdx == idx);
  endtask

  task automatic expectRx(input int base, input logic [7:0] d, input logic fr,
                          input logic par, input logic nz, input string rq);
    chk(seenCnt == base + 1, rq, "delivery count", seenCnt - base, 1);
    chk(seenData == d, rq, "rxData", seenData, d);
    chk(seenFr == fr, rq, "errFrame", seenFr, fr);
    chk(seenPar == par, rq, "errParity", seenPar, par);
    chk(seenNz == nz, rq, "errNoise", seenNz, nz);
    @(negedge clk) rxRead = 1'b1;
    @(negedge clk) rxRead = 1'b0;
    chk(rxValid == 1'b0, "R10", "rxValid after read", rxValid, 0);
  endtask

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk);
    txData = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitLow();
    int t = 0;
    while (txd !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic waitReady();
    int t = 0;
    while (txReady !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic captureTx(input int nBits, output logic [15:0] bits);
    bits = '0;
    waitLow();
    repeat (8 * P) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < nBits; k++) begin
      repeat (16 * P) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  function automatic logic [15:0] txFrame(input logic [7:0] d, input bit usePar, input logic pb);
    logic [15:0] f = '0;
    f[8:1] = d;
    if (usePar) begin
      f[9] = pb;
      f[10] = 1'b1;
    end else begin
      f[9] = 1'b1;
    end
    return f;
  endfunction

  task automatic measureStart(input int expLen, input string rq);
    int cnt = 0;
    writeTx(8'h01);
    waitLow();
    while (txd == 1'b0 && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == expLen, rq, "start bit length", cnt, expLen);
    waitReady();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] bits;
    int base;
    int lowCnt;
    int hiBase;

    repeat (4) @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11", "txd in reset", txd, 1);
    chk(txReady == 1'b1, "R11", "txReady in reset", txReady, 1);
    chk(rxValid == 1'b0, "R11", "rxValid in reset", rxValid, 0);
    chk({errFrame, errParity, errNoise} == 3'b000, "R11", "error flags in reset",
        {errFrame, errParity, errNoise}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1 bit length at divisor 3
    measureStart(64, "R1");

    // R2 plain frame, LSB first
    writeTx(8'hA5);
    captureTx(10, bits);
    chk(bits[9:0] == txFrame(8'hA5, 0, 0), "R2", "tx frame A5", bits[9:0], txFrame(8'hA5, 0, 0));
    waitReady();

    // R4 odd parity
    parityMode = 2'd2;
    writeTx(8'h03);
    captureTx(11, bits);
    chk(bits[10:0] == txFrame(8'h03, 1, 1'b1), "R4", "tx odd parity 03", bits[10:0], txFrame(8'h03, 1, 1'b1));
    waitReady();
    // R4 even parity
    parityMode = 2'd1;
    writeTx(8'h07);
    captureTx(11, bits);
    chk(bits[10:0] == txFrame(8'h07, 1, 1'b1), "R4", "tx even parity 07", bits[10:0], txFrame(8'h07, 1, 1'b1));
    waitReady();
    // R4 mode 3 means no parity: frame ends after 10 bits
    parityMode = 2'd3;
    writeTx(8'h80);
    captureTx(10, bits);
    chk(bits[9:0] == txFrame(8'h80, 0, 0), "R4", "tx mode3 frame", bits[9:0], txFrame(8'h80, 0, 0));
    repeat (8 * P + 4) @(negedge clk);
    chk(txReady == 1'b1, "R4", "ready after 10 bits in mode 3", txReady, 1);
    parityMode = 2'd0;

    // R3 write while busy is ignored
    writeTx(8'h3C);
    repeat (10) @(negedge clk);
    chk(txReady == 1'b0, "R3", "busy after write", txReady, 0);
    writeTx(8'hFF);
    captureTx(10, bits);
    chk(bits[9:0] == txFrame(8'h3C, 0, 0), "R3", "frame unaffected by busy write", bits[9:0], txFrame(8'h3C, 0, 0));
    waitReady();
    lowCnt = 0;
    for (int c = 0; c < 32 * P; c++) begin
      @(negedge clk);
      if (txd == 1'b0) lowCnt++;
    end
    chk(lowCnt == 0, "R3", "no frame from ignored write", lowCnt, 0);

    // R5 plain reception
    base = seenCnt;
    sendFrame(8'h5A, 0, 0, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'h5A, 0, 0, 0, "R5");

    // R9 parity reception
    parityMode = 2'd1;
    base = seenCnt;
    sendFrame(8'hC3, 1, ^8'hC3, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'hC3, 0, 0, 0, "R9");
    base = seenCnt;
    sendFrame(8'hC3, 1, ~(^8'hC3), 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'hC3, 0, 1, 0, "R9");
    parityMode = 2'd2;
    base = seenCnt;
    sendFrame(8'h15, 1, ~(^8'h15), 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'h15, 0, 0, 0, "R9");
    base = seenCnt;
    sendFrame(8'h15, 1, ^8'h15, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'h15, 0, 1, 0, "R9");
    parityMode = 2'd0;

    // R6 noise on a data bit, the start bit and the stop bit
    base = seenCnt;
    sendFrame(8'h6B, 0, 0, 1'b1, 3);
    sendBit(1'b1, 0);
    expectRx(base, 8'h6B, 0, 0, 1, "R6");
    base = seenCnt;
    sendFrame(8'h24, 0, 0, 1'b1, 0);
    sendBit(1'b1, 0);
    expectRx(base, 8'h24, 0, 0, 1, "R6");
    base = seenCnt;
    sendFrame(8'hE7, 0, 0, 1'b1, 9);
    sendBit(1'b1, 0);
    expectRx(base, 8'hE7, 0, 0, 1, "R6");

    // R7 short low glitch is not a start
    base = seenCnt;
    repeat (2 * P) @(negedge clk) rxdDrv = 1'b0;
    @(negedge clk) rxdDrv = 1'b1;
    sendBit(1'b1, 0);
    sendBit(1'b1, 0);
    chk(seenCnt == base, "R7", "glitch deliveries", seenCnt - base, 0);
    chk(rxValid == 1'b0, "R7", "rxValid after glitch", rxValid, 0);
    sendFrame(8'h99, 0, 0, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'h99, 0, 0, 0, "R7");

    // R8 low stop bit, then line held low
    base = seenCnt;
    sendFrame(8'h81, 0, 0, 1'b0, -1);
    expectRx(base, 8'h81, 1, 0, 0, "R8");
    base = seenCnt;
    for (int b = 0; b < 12; b++) sendBit(1'b0, 0);
    chk(seenCnt == base, "R8", "no start while line stays low", seenCnt - base, 0);
    sendBit(1'b1, 0);
    sendFrame(8'h42, 0, 0, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'h42, 0, 0, 0, "R8");

    // R10 read strobe held through a delivery
    base = seenCnt;
    hiBase = hiCnt;
    @(negedge clk) rxRead = 1'b1;
    sendFrame(8'h3D, 0, 0, 1'b1, -1);
    sendBit(1'b1, 0);
    chk(hiCnt - hiBase == 1, "R10", "valid cycles under held read", hiCnt - hiBase, 1);
    chk(seenData == 8'h3D, "R10", "data seen under held read", seenData, 8'h3D);
    chk(seenCnt == base + 1, "R10", "deliveries under held read", seenCnt - base, 1);
    @(negedge clk) rxRead = 1'b0;

    // R1 bit length at divisor 1, and reception at that rate
    @(negedge clk) baudDiv = 16'd1;
    P = 2;
    repeat (4) @(negedge clk);
    measureStart(32, "R1");
    base = seenCnt;
    sendFrame(8'hB4, 0, 0, 1'b1, -1);
    sendBit(1'b1, 0);
    expectRx(base, 8'hB4, 0, 0, 0, "R1");

    // Loopback: transmitter and receiver busy together (R2, R9)
    parityMode = 2'd2;
    @(negedge clk) loop = 1'b1;
    base = seenCnt;
    writeTx(8'h6E);
    repeat (5) @(negedge clk);
    waitReady();
    repeat (4) @(negedge clk);
    expectRx(base, 8'h6E, 0, 0, 0, "R2");
    @(negedge clk) loop = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule